// File: doc/BRIEF.md
# Peripheral Security Attribution Gate

This block sits between a simple single-cycle register bus and a row of peripheral register blocks, and filters every access according to who owns the target peripheral. Each peripheral has an ownership attribute bit that is captured from a fuse vector while reset is asserted. After reset the bit can be read back but not changed. A bit of 1 makes the peripheral open to both security states. A bit of 0 reserves it for secure accesses. A non-secure access to such a peripheral is dropped, reads as zero, and raises an error.

Some peripherals are built as mixed-security parts. When a mixed part is secure-owned, its register window appears twice: once behind a secure alias and once behind a non-secure alias. A sharing mask kept in the gate decides which register bit fields the non-secure alias may reach. Only a secure access through the secure alias can change that mask. Non-secure-alias writes to closed fields are masked off bit by bit, and reads of those fields return zero. Errors produce a one-cycle pulse and set a sticky status bit. Software clears the status bit with a secure write of 1.

The peripheral access leaves the gate in the same cycle as the bus request, and the read data returns in that same cycle.

Top module: `psg_gate`

## Requirements
- R1: The attribute vector is loaded from `fuse_i` while `rst_n` is low and holds afterwards. Later changes on `fuse_i` and bus writes to the control register at word offset 0 leave it unchanged. Any access, secure or not, reads it at that offset in bits [NUM_PERIPH-1:0].
- R2: Address layout, from the top bit down, is: a control-region bit, then the peripheral index, then an alias bit (1 = non-secure alias), then the word offset. A peripheral whose attribute bit is 1 gets full access from both states through either alias, even when it is a mixed-security part.
- R3: A plain (not mixed) peripheral whose attribute bit is 0 gets full access from secure accesses. A non-secure access raises no select, carries an all-zero bit mask, reads 0 and counts as a violation.
- R4: A violation drives `err_o` high for exactly the one cycle after the access and sets the sticky status bit, which reads at control offset 1, bit 0. A secure write with `wdata_i[0]`=1 and `be_i[0]`=1 to that offset clears it. A non-secure write there has no effect.
- R5: For a secure-owned mixed peripheral, the secure alias behaves as in R3: secure accesses pass and non-secure accesses are violations.
- R6: For a secure-owned mixed peripheral, the non-secure alias selects the peripheral for either state. Register bit b is open when sharing-mask bit b/(DATA_W/NUM_RES) is 1. Closed bits are cleared from the write bit mask and from the read data.
- R7: The sharing mask of a mixed peripheral sits at the highest word offset of its window and resets to 0. It is written from `wdata_i[NUM_RES-1:0]` only by a secure write through the secure alias with `be_i[0]`=1. Any other write leaves it unchanged and raises no error. It reads back through either alias unless the access is a violation under R5, which reads 0. That offset never selects the peripheral.
- R8: On a granted access, `p_bmask_o` is the byte enables expanded to bits (byte k covers bits 8k+7..8k) on writes and zero on reads. `p_wr_o`, `p_off_o` and `p_wdata_o` follow the bus. At most one select is active.
- R9: Control-region offsets other than 0 and 1 read 0, and no control-region access selects a peripheral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, fuse capture while low |
| fuse_i | input | NUM_PERIPH | Ownership fuse vector, 1 = non-secure |
| req_i | input | 1 | Bus access strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address (control bit, index, alias, offset) |
| wdata_i | input | DATA_W | Write data |
| be_i | input | DATA_W/8 | Byte enables |
| sec_i | input | 1 | 1 = access issued from the secure state |
| rdata_o | output | DATA_W | Read data, same cycle |
| err_o | output | 1 | One-cycle violation pulse |
| p_sel_o | output | NUM_PERIPH | One-hot peripheral select |
| p_wr_o | output | 1 | Peripheral write strobe |
| p_off_o | output | REG_AW | Peripheral word offset |
| p_wdata_o | output | DATA_W | Peripheral write data |
| p_bmask_o | output | DATA_W | Per-bit write enable after filtering |
| p_rdata_i | input | NUM_PERIPH*DATA_W | Read data of all peripherals, packed by index |

## Verification
The bench sweeps every combination of peripheral, alias, security state, direction and a normal versus mask-register offset, under two fuse patterns. Each response is compared with an access model computed arithmetically. The corners are as follows:
- A secure access through the non-secure alias must still be filtered. A design that checked only the state bit would expose closed fields.
- A mixed part marked non-secure must ignore its mask. A design that checked the mask anyway would zero open registers.
- A non-secure write to the mask register must leave it unchanged without an error. A design that confused this with a violation would raise a spurious error.
- Fuse changes after reset must not reach the attribute vector. A design with a transparent fuse path would let ownership flip at run time.

// File: rtl/psg_pkg.sv
package psg_pkg;

  // outcome of the access decoder for one bus request
  typedef enum logic [2:0] {
    ACC_IDLE = 3'd0,
    ACC_CTRL = 3'd1,
    ACC_FULL = 3'd2,
    ACC_FILT = 3'd3,
    ACC_MASK = 3'd4,
    ACC_DENY = 3'd5
  } acc_kind_e;

endpackage

// File: rtl/psg_attr_store.sv
module psg_attr_store #(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PERIPH-1:0] fuse_i,
  input  logic                  viol_i,
  input  logic                  clr_i,
  output logic [NUM_PERIPH-1:0] attr_q,
  output logic                  err_stat_q,
  output logic                  err_pulse_q
);

  // ownership bits follow the fuses only while reset is held
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attr_q <= fuse_i;
    else        attr_q <= attr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_stat_q  <= 1'b0;
      err_pulse_q <= 1'b0;
    end else begin
      err_pulse_q <= viol_i;
      if (viol_i)     err_stat_q <= 1'b1;
      else if (clr_i) err_stat_q <= 1'b0;
    end
  end

endmodule

// File: rtl/psg_share_masks.sv
module psg_share_masks #(
  parameter int                  NUM_PERIPH = 4,
  parameter int                  NUM_RES    = 8,
  parameter logic [NUM_PERIPH-1:0] MIXED_MAP = '0,
  localparam int                 PIDX_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [PIDX_W-1:0]             widx_i,
  input  logic [NUM_RES-1:0]            wval_i,
  output logic [NUM_PERIPH*NUM_RES-1:0] mask_flat_o
);

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_slot
    if (MIXED_MAP[g]) begin : g_reg
      logic [NUM_RES-1:0] m_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       m_q <= '0;
        else if (we_i && (32'(widx_i) == 32'(g)))         m_q <= wval_i;
      end
      assign mask_flat_o[g*NUM_RES +: NUM_RES] = m_q;
    end else begin : g_none
      assign mask_flat_o[g*NUM_RES +: NUM_RES] = '0;
    end
  end

endmodule

// File: rtl/psg_decode.sv
module psg_decode
  import psg_pkg::*;
#(
  parameter int                    NUM_PERIPH = 4,
  parameter int                    REG_AW     = 3,
  parameter logic [NUM_PERIPH-1:0] MIXED_MAP  = '0,
  localparam int                   PIDX_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                  req_i,
  input  logic                  ctrl_i,
  input  logic [PIDX_W-1:0]     pidx_i,
  input  logic                  alias_ns_i,
  input  logic [REG_AW-1:0]     off_i,
  input  logic                  sec_i,
  input  logic [NUM_PERIPH-1:0] attr_i,
  output acc_kind_e             kind_o
);

  localparam logic [REG_AW-1:0] MASK_OFF = '1;

  logic        in_range;
  logic        is_mixed;
  logic        owner_ns;

  always_comb begin
    in_range = 32'(pidx_i) < 32'(NUM_PERIPH);
    is_mixed = in_range && MIXED_MAP[pidx_i];
    owner_ns = in_range && attr_i[pidx_i];
    if (!req_i)                         kind_o = ACC_IDLE;
    else if (ctrl_i)                    kind_o = ACC_CTRL;
    else if (!in_range)                 kind_o = ACC_IDLE;
    else if (is_mixed && off_i == MASK_OFF)
      kind_o = (!owner_ns && !sec_i && !alias_ns_i) ? ACC_DENY : ACC_MASK;
    else if (owner_ns)                  kind_o = ACC_FULL;
    else if (is_mixed && alias_ns_i)    kind_o = ACC_FILT;
    else if (sec_i)                     kind_o = ACC_FULL;
    else                                kind_o = ACC_DENY;
  end

endmodule

// File: rtl/psg_gate.sv
module psg_gate
  import psg_pkg::*;
#(
  parameter int                    NUM_PERIPH = 4,
  parameter int                    DATA_W     = 32,
  parameter int                    REG_AW     = 3,
  parameter int                    NUM_RES    = 8,
  parameter logic [NUM_PERIPH-1:0] MIXED_MAP  = 4'b0110,
  localparam int                   PIDX_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1,
  localparam int                   ADDR_W     = 1 + PIDX_W + 1 + REG_AW,
  localparam int                   BE_W       = DATA_W / 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PERIPH-1:0]        fuse_i,
  input  logic                         req_i,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [BE_W-1:0]              be_i,
  input  logic                         sec_i,
  output logic [DATA_W-1:0]            rdata_o,
  output logic                         err_o,
  output logic [NUM_PERIPH-1:0]        p_sel_o,
  output logic                         p_wr_o,
  output logic [REG_AW-1:0]            p_off_o,
  output logic [DATA_W-1:0]            p_wdata_o,
  output logic [DATA_W-1:0]            p_bmask_o,
  input  logic [NUM_PERIPH*DATA_W-1:0] p_rdata_i
);

  localparam int                RES_W         = DATA_W / NUM_RES;
  localparam logic [REG_AW-1:0] CTRL_ATTR_OFF = '0;
  localparam logic [REG_AW-1:0] CTRL_STAT_OFF = REG_AW'(1);

  // open-field map: bit b follows mask bit b / RES_W
  function automatic logic [DATA_W-1:0] field_open(input logic [NUM_RES-1:0] m);
    logic [DATA_W-1:0] f;
    for (int b = 0; b < DATA_W; b++) f[b] = m[b / RES_W];
    return f;
  endfunction

  // byte enables spread to one bit per data bit
  function automatic logic [DATA_W-1:0] lane_bits(input logic [BE_W-1:0] e);
    logic [DATA_W-1:0] f;
    for (int b = 0; b < DATA_W; b++) f[b] = e[b / 8];
    return f;
  endfunction

  // address fields
  logic                ctrl_sel;
  logic [PIDX_W-1:0]   pidx;
  logic                alias_ns;
  logic [REG_AW-1:0]   off;

  assign off      = addr_i[REG_AW-1:0];
  assign alias_ns = addr_i[REG_AW];
  assign pidx     = addr_i[REG_AW+1 +: PIDX_W];
  assign ctrl_sel = addr_i[ADDR_W-1];

  // named internal events
  acc_kind_e                     kind;
  logic [NUM_PERIPH-1:0]         attr_q;
  logic                          err_stat_q;
  logic [NUM_PERIPH*NUM_RES-1:0] mask_flat;
  logic [NUM_RES-1:0]            cur_mask;
  logic [DATA_W-1:0]             fmask;
  logic [DATA_W-1:0]             cur_rdata;
  logic                          deny_w;
  logic                          filt_w;
  logic                          grant_w;
  logic                          mask_we;
  logic                          stat_clr;

  psg_decode #(
    .NUM_PERIPH (NUM_PERIPH),
    .REG_AW     (REG_AW),
    .MIXED_MAP  (MIXED_MAP)
  ) u_dec (
    .req_i      (req_i),
    .ctrl_i     (ctrl_sel),
    .pidx_i     (pidx),
    .alias_ns_i (alias_ns),
    .off_i      (off),
    .sec_i      (sec_i),
    .attr_i     (attr_q),
    .kind_o     (kind)
  );

  assign deny_w   = (kind == ACC_DENY);
  assign filt_w   = (kind == ACC_FILT);
  assign grant_w  = (kind == ACC_FULL) || filt_w;
  assign mask_we  = (kind == ACC_MASK) && wr_i && sec_i && !alias_ns && be_i[0];
  assign stat_clr = (kind == ACC_CTRL) && wr_i && sec_i && (off == CTRL_STAT_OFF)
                    && be_i[0] && wdata_i[0];

  psg_attr_store #(
    .NUM_PERIPH (NUM_PERIPH)
  ) u_attr (
    .clk         (clk),
    .rst_n       (rst_n),
    .fuse_i      (fuse_i),
    .viol_i      (deny_w),
    .clr_i       (stat_clr),
    .attr_q      (attr_q),
    .err_stat_q  (err_stat_q),
    .err_pulse_q (err_o)
  );

  psg_share_masks #(
    .NUM_PERIPH (NUM_PERIPH),
    .NUM_RES    (NUM_RES),
    .MIXED_MAP  (MIXED_MAP)
  ) u_masks (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (mask_we),
    .widx_i      (pidx),
    .wval_i      (wdata_i[NUM_RES-1:0]),
    .mask_flat_o (mask_flat)
  );

  assign cur_mask  = mask_flat[pidx*NUM_RES +: NUM_RES];
  assign fmask     = filt_w ? field_open(cur_mask) : '1;
  assign cur_rdata = p_rdata_i[pidx*DATA_W +: DATA_W];

  // peripheral side
  always_comb begin
    p_sel_o = '0;
    if (grant_w) p_sel_o[pidx] = 1'b1;
  end

  assign p_wr_o    = grant_w && wr_i;
  assign p_off_o   = off;
  assign p_wdata_o = wdata_i;
  assign p_bmask_o = (grant_w && wr_i) ? (lane_bits(be_i) & fmask) : '0;

  // read return
  always_comb begin
    rdata_o = '0;
    unique case (kind)
      ACC_FULL: rdata_o = cur_rdata;
      ACC_FILT: rdata_o = cur_rdata & fmask;
      ACC_MASK: rdata_o = DATA_W'(cur_mask);
      ACC_CTRL: begin
        if (off == CTRL_ATTR_OFF)      rdata_o = DATA_W'(attr_q);
        else if (off == CTRL_STAT_OFF) rdata_o = DATA_W'(err_stat_q);
      end
      default:  rdata_o = '0;
    endcase
  end

endmodule

module psg_gate_chk #(
  parameter int NUM_PERIPH = 4,
  parameter int DATA_W     = 32,
  parameter int NUM_RES    = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          deny_w,
  input logic                          filt_w,
  input logic                          mask_we,
  input logic                          wr_i,
  input logic                          err_o,
  input logic                          err_stat_q,
  input logic [NUM_PERIPH-1:0]         attr_q,
  input logic [NUM_PERIPH-1:0]         p_sel_o,
  input logic [DATA_W-1:0]             p_bmask_o,
  input logic [DATA_W-1:0]             fmask,
  input logic [NUM_PERIPH*NUM_RES-1:0] mask_flat
);

  AST_ATTR_FIXED:   assert property (@(posedge clk) disable iff (!rst_n)
                      $stable(attr_q)); // R1
  AST_DENY_NO_SEL:  assert property (@(posedge clk) disable iff (!rst_n)
                      deny_w |-> (p_sel_o == '0 && p_bmask_o == '0)); // R3
  AST_ERR_FOLLOWS:  assert property (@(posedge clk) disable iff (!rst_n)
                      deny_w |=> (err_o && err_stat_q)); // R4
  AST_ERR_CAUSE:    assert property (@(posedge clk) disable iff (!rst_n)
                      !deny_w |=> !err_o); // R4
  AST_FILT_CLOSED:  assert property (@(posedge clk) disable iff (!rst_n)
                      (filt_w && wr_i) |-> ((p_bmask_o & ~fmask) == '0)); // R6
  AST_MASK_GUARD:   assert property (@(posedge clk) disable iff (!rst_n)
                      !$stable(mask_flat) |-> $past(mask_we)); // R7
  AST_SEL_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n)
                      $onehot0(p_sel_o)); // R8

endmodule

bind psg_gate psg_gate_chk #(
  .NUM_PERIPH (NUM_PERIPH),
  .DATA_W     (DATA_W),
  .NUM_RES    (NUM_RES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .deny_w     (deny_w),
  .filt_w     (filt_w),
  .mask_we    (mask_we),
  .wr_i       (wr_i),
  .err_o      (err_o),
  .err_stat_q (err_stat_q),
  .attr_q     (attr_q),
  .p_sel_o    (p_sel_o),
  .p_bmask_o  (p_bmask_o),
  .fmask      (fmask),
  .mask_flat  (mask_flat)
);

// File: tb/psg_gate_test.sv
`timescale 1ns/1ps
module psg_gate_test;

  localparam int NP   = 4;
  localparam int DW   = 32;
  localparam int RAW  = 3;
  localparam int NR   = 8;
  localparam logic [NP-1:0] MIX = 4'b0110;
  localparam int AW   = 1 + 2 + 1 + RAW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] fuse = '0;
  logic          req = 1'b0, wr = 1'b0, sec = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [3:0]    be = '0;
  logic [DW-1:0] rdata, p_wdata, p_bmask;
  logic          err, p_wr;
  logic [NP-1:0] p_sel;
  logic [RAW-1:0] p_off;
  logic [NP*DW-1:0] p_rdata;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] word_of(input int p);
    return 32'hC3A5_0F96 ^ (32'h0101_0101 * (p * 37 + 11));
  endfunction

  always_comb
    for (int p = 0; p < NP; p++) p_rdata[p*DW +: DW] = word_of(p);

  psg_gate #(.NUM_PERIPH(NP), .DATA_W(DW), .REG_AW(RAW), .NUM_RES(NR), .MIXED_MAP(MIX)) uut (
    .clk(clk), .rst_n(rst_n), .fuse_i(fuse), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .sec_i(sec), .rdata_o(rdata), .err_o(err),
    .p_sel_o(p_sel), .p_wr_o(p_wr), .p_off_o(p_off), .p_wdata_o(p_wdata),
    .p_bmask_o(p_bmask), .p_rdata_i(p_rdata));

  // bench-side model state
  logic [NP-1:0] m_attr;
  logic [NR-1:0] m_mask [NP];
  logic          m_stat;

  task automatic chk(input string req_tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // expand a sharing mask nibble-group by nibble-group
  function automatic logic [DW-1:0] open_bits(input logic [NR-1:0] m);
    logic [DW-1:0] r = '0;
    for (int i = 0; i < NR; i++) if (m[i]) r = r | (32'hF << (4 * i));
    return r;
  endfunction

  function automatic logic [DW-1:0] be_bits(input logic [3:0] e);
    logic [DW-1:0] r = '0;
    for (int k = 0; k < 4; k++) if (e[k]) r = r | (32'hFF << (8 * k));
    return r;
  endfunction

  // one peripheral-region access, checked against the model
  task automatic pacc(input int p, input bit a, input bit s, input bit w,
                      input logic [RAW-1:0] o, input logic [3:0] e, input logic [DW-1:0] d);
    bit mixed, at, is_mreg, filt, full, deny, wok;
    logic [DW-1:0] fld, exp_rd, exp_bm;
    logic [NP-1:0] exp_sel;
    string tag;
    mixed = MIX[p]; at = m_attr[p];
    is_mreg = mixed && (o == 3'd7);
    if (is_mreg) begin
      deny = !at && !s && !a; filt = 0; full = 0;
      wok = w && s && !a && e[0];
      exp_rd = deny ? '0 : DW'(m_mask[p]);
      exp_sel = '0; exp_bm = '0;
      tag = deny ? "R5" : "R7";
    end else begin
      wok = 0;
      filt = !at && mixed && a;
      full = at || (!filt && s);
      deny = !full && !filt;
      fld = filt ? open_bits(m_mask[p]) : '1;
      exp_sel = (full || filt) ? NP'(1 << p) : '0;
      exp_bm = (w && (full || filt)) ? (be_bits(e) & fld) : '0;
      exp_rd = full ? word_of(p) : (filt ? (word_of(p) & fld) : '0);
      if (at) tag = "R2";
      else if (filt) tag = "R6";
      else if (mixed) tag = "R5";
      else tag = "R3";
    end
    @(negedge clk);
    req = 1; wr = w; sec = s; be = e; wdata = d;
    addr = {1'b0, 2'(p), a, o};
    #2;
    chk({tag, " sel"}, DW'(p_sel), DW'(exp_sel));
    if (w) chk({tag, " bmask R8"}, p_bmask, exp_bm);
    else   chk({tag, " rdata"}, rdata, exp_rd);
    if (w && (full || filt)) chk("R8 wr/wdata", {p_wr, p_wdata[30:0]}, {1'b1, d[30:0]});
    @(negedge clk);
    chk("R4 err pulse", DW'(err), DW'(deny));
    if (deny) m_stat = 1;
    if (wok) m_mask[p] = d[NR-1:0];
    req = 0;
    @(negedge clk);
    chk("R4 err single", DW'(err), '0);
  endtask

  task automatic cacc(input bit s, input bit w, input logic [RAW-1:0] o,
                      input logic [DW-1:0] d, output logic [DW-1:0] rd);
    @(negedge clk);
    req = 1; wr = w; sec = s; be = 4'hF; wdata = d;
    addr = {1'b1, 2'd0, 1'b0, o};
    #2;
    rd = rdata;
    chk("R9 no select", DW'(p_sel), '0);
    @(negedge clk);
    req = 0;
  endtask

  task automatic do_reset(input logic [NP-1:0] f);
    @(negedge clk);
    rst_n = 0; fuse = f;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_attr = f; m_stat = 0;
    for (int p = 0; p < NP; p++) m_mask[p] = '0;
  endtask

  task automatic sweep(input int seed);
    int n = seed;
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < 2; a++)
        for (int s = 0; s < 2; s++)
          for (int w = 0; w < 2; w++)
            for (int oi = 0; oi < 2; oi++) begin
              n++;
              pacc(p, a[0], s[0], w[0], oi ? 3'd7 : 3'((p + a + 2) % 7),
                   4'((n * 5 + 3) % 16) | 4'b0001, 32'h1357_9BDF ^ (32'h0001_0203 * n));
            end
  endtask

  logic [DW-1:0] rd;

  initial begin
    // config A: every peripheral secure-owned
    do_reset(4'b0000);
    chk("R4 reset err", DW'(err), '0);
    chk("R8 reset sel", DW'(p_sel), '0);
    fuse = 4'b1111;                               // R1: late fuse change
    cacc(1, 1, 3'd0, 32'hFFFF_FFFF, rd);          // R1: write to attributes
    cacc(0, 0, 3'd0, 0, rd); chk("R1 attr read ns", rd, 32'h0);
    // open some fields: periph 1 mask 0x05, periph 2 mask 0xF0
    pacc(1, 0, 1, 1, 3'd7, 4'h1, 32'h0000_0005);
    pacc(2, 0, 1, 1, 3'd7, 4'h1, 32'h0000_00F0);
    pacc(2, 1, 0, 1, 3'd7, 4'h1, 32'h0000_00FF);  // R7 ns-alias write ignored
    pacc(2, 0, 1, 1, 3'd7, 4'h2, 32'h0000_00AA);  // R7 be[0]=0 ignored
    pacc(1, 1, 0, 0, 3'd2, 4'hF, 0);              // R6 filtered read
    pacc(1, 1, 1, 1, 3'd3, 4'hF, 32'hFFFF_FFFF);  // R6 secure via ns alias
    sweep(0);
    cacc(0, 0, 3'd1, 0, rd); chk("R4 status set", rd, DW'(m_stat));
    cacc(0, 1, 3'd1, 32'h1, rd);                  // non-secure clear: no effect
    cacc(1, 0, 3'd1, 0, rd); chk("R4 status after ns clear", rd, 32'h1);
    cacc(1, 1, 3'd1, 32'h1, rd);
    cacc(1, 0, 3'd1, 0, rd); chk("R4 status cleared", rd, 32'h0);
    cacc(1, 0, 3'd5, 0, rd); chk("R9 unused ctrl", rd, 32'h0);
    // config B: periph 1 (mixed) and 3 non-secure
    do_reset(4'b1010);
    chk("R4 reset err B", DW'(err), '0);
    cacc(1, 0, 3'd0, 0, rd); chk("R1 attr read", rd, 32'hA);
    pacc(1, 0, 1, 1, 3'd7, 4'h1, 32'h0000_0000);
    pacc(2, 0, 1, 1, 3'd7, 4'h1, 32'h0000_003C);
    sweep(100);
    cacc(0, 0, 3'd1, 0, rd); chk("R4 status B", rd, DW'(m_stat));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule